// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block picks the low-power mode the processor enters after it issues a wait request, then sequences the entry and the return to Run. The deep-sleep flag chooses between a light mode and a deep mode. In the light mode only the CPU clock halts. In the deep mode a power-down select picks either a clock-stopped mode that keeps its state, or a powered-off mode whose exit restarts the device.

Entry into the clock-stopped mode has two guards. Pending flags cancel the entry. Flash or bus activity holds the entry off until that activity ends. While the block is stopped, it runs the regulator at low power only when software asked for that and no peripheral is requesting its kernel clock. On the way out, a low-power regulator costs a programmable number of startup cycles. The block then asks for the internal RC oscillator as system clock. Exit from the powered-off mode accepts only reset-class sources and rising wake edges, and it produces a restart request.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset, mode_o is Run (0), reg_mode_o is on (0), and clk_stop_o, cpu_clk_off_o, hsi_sel_o and restart_o are all 0.
- R2: A wait request with deep_i=0 gives Sleep (mode_o=1) from the next cycle, with cpu_clk_off_o=1, clk_stop_o=0 and the regulator on. In Sleep, wake_irq_i returns the block to Run on the next cycle with no hsi_sel_o pulse.
- R3: A wait request with deep_i=1 and pdown_i=1 gives Standby (mode_o=3) from the next cycle, with reg_mode_o=off (2) and clk_stop_o=1.
- R4: A wait request with deep_i=1, pdown_i=0, pend_any_i=0 and no busy input gives Stop (mode_o=2) from the next cycle, with clk_stop_o=1. In Stop, reg_mode_o is low-power (1) when lpreg_i=1 and no kernel-clock request is set. Otherwise it is on (0).
- R5: While mode_o is Stop, any set bit of kclk_req_i forces reg_mode_o to on (0) in the same cycle, whatever lpreg_i is.
- R6: A Stop request while pend_any_i=1 is discarded, and mode_o stays Run. pend_any_i=1 during a deferred entry also cancels that entry.
- R7: A Stop request while flash_busy_i or bus_busy_i is 1 keeps mode_o at Run. Stop follows one cycle after the cycle in which both busy inputs are 0.
- R8: wake_irq_i in Stop with the regulator on returns mode_o to Run on the next cycle. hsi_sel_o is high for exactly that first Run cycle.
- R9: wake_irq_i in Stop with the regulator at low power and wake_dly_i=D>0 keeps mode_o at Stop for D more cycles, with the regulator on and clk_stop_o=1. Run then follows with a one-cycle hsi_sel_o pulse. With D=0 the exit behaves as in R8.
- R10: Standby is left only on pin_reset_i, wdg_reset_i, a rising edge of wake_pin_i or a rising edge of alarm_i. wake_irq_i and a wake level already high are ignored. The exit gives Run on the next cycle with restart_o high for one cycle.
- R11: wait_req_i has no effect outside Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wait_req_i | input | 1 | Wait-for-interrupt/event request from the CPU |
| deep_i | input | 1 | Deep-sleep flag |
| pdown_i | input | 1 | Power-down select: 1 Standby, 0 Stop |
| lpreg_i | input | 1 | Low-power regulator select for Stop |
| pend_any_i | input | 1 | OR of line, peripheral and alarm pending flags |
| flash_busy_i | input | 1 | Flash programming ongoing |
| bus_busy_i | input | 1 | Peripheral bus access ongoing |
| kclk_req_i | input | NKCLK | Peripheral kernel-clock requests |
| wake_irq_i | input | 1 | Interrupt/event wakeup for Sleep and Stop |
| wake_pin_i | input | 1 | Wake pin level |
| alarm_i | input | 1 | Alarm level |
| wdg_reset_i | input | 1 | Watchdog reset request |
| pin_reset_i | input | 1 | External reset pin request |
| wake_dly_i | input | DLY_W | Regulator wakeup delay in cycles |
| mode_o | output | 2 | 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| reg_mode_o | output | 2 | 0 on, 1 low-power, 2 off |
| clk_stop_o | output | 1 | Domain clocks stopped |
| cpu_clk_off_o | output | 1 | CPU clock gated |
| hsi_sel_o | output | 1 | One-cycle request to switch the system clock to the internal RC oscillator |
| restart_o | output | 1 | One-cycle reset-style restart request |

## Verification
Every mode change and every exit pulse is due one clock after the edge that samples its cause. The one exception is a low-power Stop exit, which lands D+1 edges after the wake edge. The regulator mode follows kclk_req_i and lpreg_i in the same cycle. The bench drives inputs one time unit after a rising edge and reads the directed results at that point, using cycle counts worked out from the requirements. A behavioural model, updated on the same rising edges, is compared with all outputs at every falling edge.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {MODE_RUN, MODE_SLEEP, MODE_STOP, MODE_STBY} pwr_mode_e;
  typedef enum logic [1:0] {REG_ON, REG_LP, REG_OFF} reg_mode_e;
  typedef enum logic [2:0] {S_RUN, S_DEFER, S_SLEEP, S_STOP, S_WAKE, S_STBY} lp_state_e;
  typedef enum logic [2:0] {E_SLEEP, E_STBY, E_ABORT, E_DEFER, E_STOP} entry_e;
endpackage

// File: rtl/lp_entry_decide.sv
module lp_entry_decide
  import lp_pkg::*;
(
  input  logic   deep_i,
  input  logic   pdown_i,
  input  logic   pend_i,
  input  logic   busy_i,
  output entry_e entry_o
);
  always_comb begin
    if (!deep_i)     entry_o = E_SLEEP;
    else if (pdown_i) entry_o = E_STBY;
    else if (pend_i)  entry_o = E_ABORT;
    else if (busy_i)  entry_o = E_DEFER;
    else              entry_o = E_STOP;
  end
endmodule

// File: rtl/lp_edge_det.sv
module lp_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign expire_o = (cnt_q == ONE);

  // idle counter never wraps
  assert_timer_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int NKCLK = 3,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wait_req_i,
  input  logic             deep_i,
  input  logic             pdown_i,
  input  logic             lpreg_i,
  input  logic             pend_any_i,
  input  logic             flash_busy_i,
  input  logic             bus_busy_i,
  input  logic [NKCLK-1:0] kclk_req_i,
  input  logic             wake_irq_i,
  input  logic             wake_pin_i,
  input  logic             alarm_i,
  input  logic             wdg_reset_i,
  input  logic             pin_reset_i,
  input  logic [DLY_W-1:0] wake_dly_i,
  output logic [1:0]       mode_o,
  output logic [1:0]       reg_mode_o,
  output logic             clk_stop_o,
  output logic             cpu_clk_off_o,
  output logic             hsi_sel_o,
  output logic             restart_o
);
  localparam int NSRC = 2;

  lp_state_e   st_q, st_d;
  logic        hsi_q, hsi_d, rsq_q, rsq_d;
  logic [NSRC-1:0] rise;
  entry_e      entry;
  logic        busy, lp_sel, lp_wake, expire, stby_exit;
  pwr_mode_e   mode;
  reg_mode_e   regm;

  assign busy   = flash_busy_i | bus_busy_i;
  assign lp_sel = lpreg_i & ~(|kclk_req_i);

  lp_edge_det #(.N(NSRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({alarm_i, wake_pin_i}),
    .rise_o (rise)
  );

  lp_entry_decide u_dec (
    .deep_i  (deep_i),
    .pdown_i (pdown_i),
    .pend_i  (pend_any_i),
    .busy_i  (busy),
    .entry_o (entry)
  );

  assign lp_wake   = (st_q == S_STOP) & wake_irq_i & lp_sel & (wake_dly_i != '0);
  assign stby_exit = pin_reset_i | wdg_reset_i | (|rise);

  lp_wake_timer #(.W(DLY_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (lp_wake),
    .val_i    (wake_dly_i),
    .expire_o (expire)
  );

  always_comb begin
    st_d  = st_q;
    hsi_d = 1'b0;
    rsq_d = 1'b0;
    unique case (st_q)
      S_RUN: if (wait_req_i) begin
        unique case (entry)
          E_SLEEP: st_d = S_SLEEP;
          E_STBY:  st_d = S_STBY;
          E_DEFER: st_d = S_DEFER;
          E_STOP:  st_d = S_STOP;
          default: st_d = S_RUN;
        endcase
      end
      S_DEFER: begin
        if (pend_any_i) st_d = S_RUN;
        else if (!busy) st_d = S_STOP;
      end
      S_SLEEP: if (wake_irq_i) st_d = S_RUN;
      S_STOP: if (wake_irq_i) begin
        if (lp_wake) st_d = S_WAKE;
        else begin
          st_d  = S_RUN;
          hsi_d = 1'b1;
        end
      end
      S_WAKE: if (expire) begin
        st_d  = S_RUN;
        hsi_d = 1'b1;
      end
      S_STBY: if (stby_exit) begin
        st_d  = S_RUN;
        rsq_d = 1'b1;
      end
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_RUN;
      hsi_q <= 1'b0;
      rsq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hsi_q <= hsi_d;
      rsq_q <= rsq_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_SLEEP:        mode = MODE_SLEEP;
      S_STOP, S_WAKE: mode = MODE_STOP;
      S_STBY:         mode = MODE_STBY;
      default:        mode = MODE_RUN;
    endcase
    if (st_q == S_STBY)                regm = REG_OFF;
    else if (st_q == S_STOP && lp_sel) regm = REG_LP;
    else                               regm = REG_ON;
  end

  assign mode_o        = mode;
  assign reg_mode_o    = regm;
  assign clk_stop_o    = (st_q == S_STOP) | (st_q == S_WAKE) | (st_q == S_STBY);
  assign cpu_clk_off_o = (st_q != S_RUN) & (st_q != S_DEFER);
  assign hsi_sel_o     = hsi_q;
  assign restart_o     = rsq_q;

  assert_sleep_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RUN && wait_req_i && !deep_i) |=> (mode_o == MODE_SLEEP));
  assert_pend_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RUN && wait_req_i && deep_i && !pdown_i && pend_any_i) |=> (mode_o == MODE_RUN));
  assert_busy_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DEFER && busy) |=> (mode_o == MODE_RUN));
  assert_hsi_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsi_sel_o |=> !hsi_sel_o);
  assert_restart_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> ($past(st_q) == S_STBY && mode_o == MODE_RUN));
  assert_req_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SLEEP && !wake_irq_i) |=> (mode_o == MODE_SLEEP));
endmodule

// File: tb/lp_mode_ctrl_test.sv
module lp_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, deep = 0, pdn = 0, lpr = 0, pend = 0, fbusy = 0, bbusy = 0;
  logic [2:0] kclk = '0;
  logic irq = 0, wpin = 0, alrm = 0, wdg = 0, prst = 0;
  logic [7:0] dly = 8'd3;
  logic [1:0] mode, regm;
  logic cstop, coff, hsi, rsq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lp_mode_ctrl #(.NKCLK(3), .DLY_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wait_req_i(req), .deep_i(deep), .pdown_i(pdn),
    .lpreg_i(lpr), .pend_any_i(pend), .flash_busy_i(fbusy), .bus_busy_i(bbusy),
    .kclk_req_i(kclk), .wake_irq_i(irq), .wake_pin_i(wpin), .alarm_i(alrm),
    .wdg_reset_i(wdg), .pin_reset_i(prst), .wake_dly_i(dly),
    .mode_o(mode), .reg_mode_o(regm), .clk_stop_o(cstop), .cpu_clk_off_o(coff),
    .hsi_sel_o(hsi), .restart_o(rsq)
  );

  // reference model: 0 run 1 sleep 2 stop 3 standby 4 waking 5 deferred
  int ms, mc;
  bit m_hsi, m_rs, pw, pa;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; mc <= 0; m_hsi <= 0; m_rs <= 0; pw <= 0; pa <= 0;
    end else begin
      m_hsi <= 0; m_rs <= 0; pw <= wpin; pa <= alrm;
      if (ms == 0 && req) begin
        if (!deep) ms <= 1;
        else if (pdn) ms <= 3;
        else if (pend) ms <= 0;
        else if (fbusy || bbusy) ms <= 5;
        else ms <= 2;
      end else if (ms == 5) begin
        if (pend) ms <= 0;
        else if (!fbusy && !bbusy) ms <= 2;
      end else if (ms == 1 && irq) ms <= 0;
      else if (ms == 2 && irq) begin
        if (lpr && kclk == 0 && dly != 0) begin ms <= 4; mc <= int'(dly); end
        else begin ms <= 0; m_hsi <= 1; end
      end else if (ms == 4) begin
        if (mc == 1) begin ms <= 0; m_hsi <= 1; end
        else mc <= mc - 1;
      end else if (ms == 3 && (prst || wdg || (wpin && !pw) || (alrm && !pa))) begin
        ms <= 0; m_rs <= 1;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int em, er;
    em = (ms == 4) ? 2 : (ms == 5) ? 0 : ms;
    er = (ms == 3) ? 2 : (ms == 2 && lpr && kclk == 0) ? 1 : 0;
    chk(int'(mode), em, "R4 model mode");
    chk(int'(regm), er, "R5 model regulator");
    chk(int'(cstop), int'(ms == 2 || ms == 3 || ms == 4), "R3 model clk_stop");
    chk(int'(coff), int'(ms >= 1 && ms <= 4), "R2 model cpu_clk_off");
    chk(int'(hsi), int'(m_hsi), "R8 model hsi_sel");
    chk(int'(rsq), int'(m_rs), "R10 model restart");
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_req();
    req = 1; tick(); req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(int'(mode), 0, "R1 mode"); chk(int'(regm), 0, "R1 reg");
    chk(int'(cstop), 0, "R1 clk_stop"); chk(int'(coff), 0, "R1 cpu_off");
    chk(int'(hsi), 0, "R1 hsi"); chk(int'(rsq), 0, "R1 restart");
    @(negedge clk); rst_n = 1; tick();
    chk(int'(mode), 0, "R1 mode after release");

    // sleep
    deep = 0; pulse_req();
    chk(int'(mode), 1, "R2 sleep"); chk(int'(coff), 1, "R2 cpu_off"); chk(int'(cstop), 0, "R2 clk_stop");
    deep = 1; pdn = 1; pulse_req();
    chk(int'(mode), 1, "R11 request in sleep ignored");
    pdn = 0; irq = 1; tick(); irq = 0;
    chk(int'(mode), 0, "R2 sleep exit"); chk(int'(hsi), 0, "R2 no hsi");

    // stop with low-power regulator and delayed exit
    deep = 1; pdn = 0; lpr = 1; pulse_req();
    chk(int'(mode), 2, "R4 stop"); chk(int'(regm), 1, "R4 lp regulator"); chk(int'(cstop), 1, "R4 clk_stop");
    kclk = 3'b010; #1;
    chk(int'(regm), 0, "R5 kclk forces on");
    kclk = 3'b000; #1;
    chk(int'(regm), 1, "R5 lp restored");
    irq = 1; tick(); irq = 0;
    chk(int'(mode), 2, "R9 wake cycle 1"); chk(int'(regm), 0, "R9 reg on while waking");
    tick(); chk(int'(mode), 2, "R9 wake cycle 2");
    tick(); chk(int'(mode), 2, "R9 wake cycle 3"); chk(int'(cstop), 1, "R9 clk_stop while waking");
    tick(); chk(int'(mode), 0, "R9 run after delay"); chk(int'(hsi), 1, "R9 hsi pulse");
    tick(); chk(int'(hsi), 0, "R8 hsi single cycle");

    // stop with regulator on
    lpr = 0; pulse_req();
    chk(int'(mode), 2, "R4 stop reg on"); chk(int'(regm), 0, "R4 reg on");
    irq = 1; tick(); irq = 0;
    chk(int'(mode), 0, "R8 immediate exit"); chk(int'(hsi), 1, "R8 hsi pulse");
    tick();

    // zero delay with low-power regulator
    lpr = 1; dly = 0; pulse_req();
    irq = 1; tick(); irq = 0;
    chk(int'(mode), 0, "R9 zero delay exit"); chk(int'(hsi), 1, "R9 zero delay hsi");
    dly = 8'd3; lpr = 0; tick();

    // pending abort
    pend = 1; pulse_req();
    chk(int'(mode), 0, "R6 abort"); tick(); chk(int'(mode), 0, "R6 still run");
    pend = 0;

    // busy defer
    fbusy = 1; pulse_req();
    chk(int'(mode), 0, "R7 deferred"); chk(int'(coff), 0, "R7 cpu clock on");
    tick(); chk(int'(mode), 0, "R7 flash busy");
    fbusy = 0; bbusy = 1; tick(); chk(int'(mode), 0, "R7 bus busy");
    bbusy = 0; tick(); chk(int'(mode), 2, "R7 stop after idle");
    irq = 1; tick(); irq = 0; tick();

    // defer cancelled by pending
    bbusy = 1; pulse_req();
    pend = 1; tick(); pend = 0; bbusy = 0;
    tick(); chk(int'(mode), 0, "R6 defer cancelled");

    // standby, level already high on wake pin
    wpin = 1; tick();
    pdn = 1; pulse_req();
    chk(int'(mode), 3, "R3 standby"); chk(int'(regm), 2, "R3 reg off"); chk(int'(cstop), 1, "R3 clk_stop");
    irq = 1; tick(); irq = 0;
    chk(int'(mode), 3, "R10 irq ignored");
    tick(); chk(int'(mode), 3, "R10 high level ignored");
    wpin = 0; tick(); chk(int'(mode), 3, "R10 falling ignored");
    wpin = 1; tick();
    chk(int'(mode), 0, "R10 wake pin exit"); chk(int'(rsq), 1, "R10 restart pulse");
    tick(); chk(int'(rsq), 0, "R10 restart single"); wpin = 0;

    pulse_req(); alrm = 1; tick(); alrm = 0;
    chk(int'(mode), 0, "R10 alarm exit"); chk(int'(rsq), 1, "R10 alarm restart");
    tick();
    pulse_req(); wdg = 1; tick(); wdg = 0;
    chk(int'(mode), 0, "R10 watchdog exit");
    tick();
    pulse_req(); prst = 1; tick(); prst = 0;
    chk(int'(mode), 0, "R10 reset pin exit"); chk(int'(rsq), 1, "R10 reset pin restart");
    pdn = 0; tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule